// File: doc/BRIEF.md
# ALU with Bus-Driven Branch Comparison

This block is the arithmetic unit of a bus-based multicycle processor. A control unit steers it. Two operand registers, A and B, capture the shared bus when their load strobes are high. A 2-bit function code selects one of four operations on those operands. The result appears on the block's bus output only while the drive enable is high. When the enable is low the output is all zeros, so the output can be OR-ed with other bus sources.

Branch decisions do not use separate comparison hardware. During a branch the control unit selects subtraction and drives A−B onto the bus. A combinational evaluator watches the bus value and forms one condition bit: equal, less-than or greater-than, selected by the 4-bit branch opcode. A flag register captures that bit on a strobe, so the control unit can choose its next state from it. Comparisons are signed and ignore overflow.

Top module: `alu_branch_unit`

## Requirements
- R1: When `ld_opa` is high at a rising clock edge, operand A takes the value of `bus_in`. Otherwise A keeps its value.
- R2: When `ld_opb` is high at a rising clock edge, operand B takes the value of `bus_in`. Otherwise B keeps its value.
- R3: Function code 2'b00 gives A+B, modulo 2^WIDTH.
- R4: Function code 2'b01 gives A−B, modulo 2^WIDTH.
- R5: Function code 2'b10 gives the bitwise NAND of A and B.
- R6: Function code 2'b11 gives A+1, modulo 2^WIDTH. B is ignored.
- R7: `bus_out` equals the selected result while `drv_alu` is high. It is all zeros while `drv_alu` is low.
- R8: With `br_opc` = 4'b0101 (equal), `cond_now` is 1 exactly when every bit of `bus_in` is 0.
- R9: With `br_opc` = 4'b1000 (less-than), `cond_now` equals the most significant bit of `bus_in`.
- R10: With `br_opc` = 4'b1010 (greater-than), `cond_now` is 1 exactly when `bus_in` is nonzero and its most significant bit is 0.
- R11: With any other value of `br_opc`, `cond_now` is 0.
- R12: When `ld_flag` is high at a rising edge, `cond_flag` takes the value `cond_now` had before that edge. Otherwise `cond_flag` holds.
- R13: When `rst_n` is low at a rising edge, A, B and `cond_flag` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_in | input | WIDTH | Current value of the shared bus |
| ld_opa | input | 1 | Load operand A from the bus |
| ld_opb | input | 1 | Load operand B from the bus |
| fn_sel | input | 2 | Operation select: 00 add, 01 subtract, 10 NAND, 11 increment A |
| drv_alu | input | 1 | Put the result on `bus_out` |
| br_opc | input | 4 | Branch opcode that picks the condition |
| ld_flag | input | 1 | Capture the condition into the flag |
| bus_out | output | WIDTH | Result when driving, zero otherwise |
| cond_now | output | 1 | Combinational condition from the bus |
| cond_flag | output | 1 | Registered condition for the control unit |

## Verification
The bench targets the sign boundary of the difference. Operand pairs such as 0x7F/0x80 and 0x80/0x7F produce wrapped differences. A design that compared the operands directly, or treated the difference as unsigned, would resolve less-than and greater-than the opposite way on those pairs. The bench also targets the zero difference: a design whose equal test ignored the top bit, or whose greater-than test did not exclude zero, would report a taken branch on equal operands. The increment case uses A = all ones, where a wrong carry path would not wrap to zero. Non-branch opcodes and undriven cycles are also checked, because a decoder without a default, or an output that leaked the result, would corrupt the wired-OR bus.

// File: rtl/alu_cmp_pkg.sv
// Shared definitions for the ALU and branch evaluator.
// Assumes a 2-bit function code and a 4-bit branch opcode field.
package alu_cmp_pkg;

    typedef enum logic [1:0] {
        FN_ADD  = 2'b00,
        FN_SUB  = 2'b01,
        FN_NAND = 2'b10,
        FN_INC  = 2'b11
    } alu_fn_e;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_EQ = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_LT = 4'b1000;
    localparam logic [OPC_W-1:0] OPC_GT = 4'b1010;

endpackage

// File: rtl/opnd_latch.sv
// Operand register: captures its input when load is high, otherwise holds.
// Assumes a synchronous active-low reset that clears it to zero.
module opnd_latch #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Capture or hold the operand value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

    // R1/R2: a load strobe copies the bus value.
    a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));

    // R1/R2: without a strobe the operand holds.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/arith_core.sv
// Combinational operation unit. A single adder serves add, subtract and
// increment by muxing its second operand and carry-in. NAND runs beside it.
// Assumes no flags are needed from the arithmetic; results wrap.
module arith_core
    import alu_cmp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  alu_fn_e          fn,
    output logic [WIDTH-1:0] res
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] add_rhs;
    logic             add_cin;
    logic [WIDTH-1:0] add_sum;
    logic [WIDTH-1:0] nand_v;

    // Pick the adder's second operand and carry for the function.
    always_comb begin
        add_rhs = opb;
        add_cin = 1'b0;
        unique case (fn)
            FN_ADD:  begin add_rhs = opb;  add_cin = 1'b0; end
            FN_SUB:  begin add_rhs = ~opb; add_cin = 1'b1; end
            FN_INC:  begin add_rhs = ONE;  add_cin = 1'b0; end
            default: begin add_rhs = opb;  add_cin = 1'b0; end
        endcase
    end

    // Shared adder with carry-in.
    always_comb add_sum = opa + add_rhs + {{(WIDTH-1){1'b0}}, add_cin};

    // Bitwise NAND path.
    always_comb nand_v = ~(opa & opb);

    // Final result select.
    always_comb res = (fn == FN_NAND) ? nand_v : add_sum;

endmodule

// File: rtl/branch_eval.sv
// Branch condition evaluator: decodes zero and sign of the bus value
// (which holds A-B during a branch) into one condition bit per opcode.
// It registers that bit on a strobe. Assumes signed compare, overflow ignored.
module branch_eval
    import alu_cmp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] bus,
    input  logic [OPC_W-1:0] opc,
    input  logic             ld_flag,
    output logic             cond_now,
    output logic             cond_flag
);

    localparam int MSB = WIDTH - 1;

    logic is_zero;
    logic is_neg;

    // Zero and sign detection on the difference.
    always_comb begin
        is_zero = ~|bus;
        is_neg  = bus[MSB];
    end

    // Opcode-selected condition.
    always_comb begin
        unique case (opc)
            OPC_EQ:  cond_now = is_zero;
            OPC_LT:  cond_now = is_neg;
            OPC_GT:  cond_now = ~is_zero & ~is_neg;
            default: cond_now = 1'b0;
        endcase
    end

    // Condition flag register for the control unit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cond_flag <= 1'b0;
        else if (ld_flag)
            cond_flag <= cond_now;
    end

    // R8: equal taken only on a zero bus.
    a_r8_eq_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_EQ && cond_now) |-> (bus == '0));

    // R10: greater-than never taken on a negative or zero difference.
    a_r10_gt_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_GT && cond_now) |-> (!bus[MSB] && bus != '0));

    // R11: non-branch opcodes give no condition.
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (opc != OPC_EQ && opc != OPC_LT && opc != OPC_GT) |-> !cond_now);

    // R12: capture and hold of the flag.
    a_r12_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ld_flag |=> (cond_flag == $past(cond_now)));
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_flag |=> $stable(cond_flag));

    // R13: reset clears the flag.
    a_r13_clear: assert property (@(posedge clk)
        !rst_n |=> !cond_flag);

endmodule

// File: rtl/alu_branch_unit.sv
// Top level: two operand registers, the operation unit with a gated
// bus output for a wired-OR bus, and the branch evaluator watching the bus.
// Assumes the bus fabric ORs bus_out with other sources into bus_in.
module alu_branch_unit
    import alu_cmp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] bus_in,
    input  logic             ld_opa,
    input  logic             ld_opb,
    input  logic [1:0]       fn_sel,
    input  logic             drv_alu,
    input  logic [3:0]       br_opc,
    input  logic             ld_flag,
    output logic [WIDTH-1:0] bus_out,
    output logic             cond_now,
    output logic             cond_flag
);

    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    logic [WIDTH-1:0] opa_q;
    logic [WIDTH-1:0] opb_q;
    logic [WIDTH-1:0] res;
    alu_fn_e          fn;

    always_comb fn = alu_fn_e'(fn_sel);

    opnd_latch #(.WIDTH(WIDTH)) u_opa (
        .clk(clk), .rst_n(rst_n), .load(ld_opa), .d(bus_in), .q(opa_q)
    );

    opnd_latch #(.WIDTH(WIDTH)) u_opb (
        .clk(clk), .rst_n(rst_n), .load(ld_opb), .d(bus_in), .q(opb_q)
    );

    arith_core #(.WIDTH(WIDTH)) u_core (
        .opa(opa_q), .opb(opb_q), .fn(fn), .res(res)
    );

    // Gate the result onto the wired-OR bus.
    always_comb bus_out = drv_alu ? res : '0;

    branch_eval #(.WIDTH(WIDTH)) u_cmp (
        .clk(clk), .rst_n(rst_n), .bus(bus_in), .opc(br_opc),
        .ld_flag(ld_flag), .cond_now(cond_now), .cond_flag(cond_flag)
    );

    // R3: sum minus B recovers A.
    a_r3_add: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_alu && fn_sel == 2'b00) |-> (bus_out - opb_q == opa_q));

    // R4: difference plus B recovers A.
    a_r4_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_alu && fn_sel == 2'b01) |-> (bus_out + opb_q == opa_q));

    // R5: NAND result is disjoint from A&B and covers its complement.
    a_r5_nand: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_alu && fn_sel == 2'b10) |->
        (((bus_out & opa_q & opb_q) == '0) && ((bus_out | (opa_q & opb_q)) == ALL_ONES)));

    // R6: increment minus one recovers A.
    a_r6_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_alu && fn_sel == 2'b11) |-> (bus_out - 1'b1 == opa_q));

    // R7: an idle unit leaves the bus clear.
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_alu |-> (bus_out == '0));

endmodule

// File: tb/sim_alu_branch_unit.sv
module sim_alu_branch_unit;

    localparam int W = 8;
    localparam time HALF = 2ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] ext_val = '0;
    logic         ld_opa = 1'b0, ld_opb = 1'b0, drv_alu = 1'b0, ld_flag = 1'b0;
    logic [1:0]   fn_sel = 2'b00;
    logic [3:0]   br_opc = 4'b0000;
    logic [W-1:0] bus_out;
    logic [W-1:0] bus_in;
    logic         cond_now, cond_flag;
    int           n_chk = 0, n_fail = 0;
    bit           done = 1'b0;

    always #(HALF) clk = ~clk;

    // Wired-OR bus: external source plus ALU contribution.
    assign bus_in = ext_val | bus_out;

    alu_branch_unit #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .ld_opa(ld_opa),
        .ld_opb(ld_opb), .fn_sel(fn_sel), .drv_alu(drv_alu), .br_opc(br_opc),
        .ld_flag(ld_flag), .bus_out(bus_out), .cond_now(cond_now),
        .cond_flag(cond_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pick_b(input int i);
        case (i)
            0: return 8'h00;  1: return 8'h01;  2: return 8'h7F;  3: return 8'h80;
            4: return 8'h81;  5: return 8'hFF;  6: return 8'hFE;  7: return 8'h7E;
            default: return W'((i * 37 + 11) & 8'hFF);
        endcase
    endfunction

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_pair(input logic [W-1:0] a, input logic [W-1:0] b);
        drv_alu = 1'b0; ext_val = a; ld_opa = 1'b1;
        cycle();
        ld_opa = 1'b0; ext_val = b; ld_opb = 1'b1;
        cycle();
        ld_opb = 1'b0; ext_val = '0;
    endtask

    task automatic test_pair(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] d;
        logic         eq, lt, gt;
        load_pair(a, b);
        d  = a - b;
        eq = (d == '0);
        lt = d[W-1];
        gt = !eq && !lt;
        fn_sel = 2'b00; drv_alu = 1'b1; #1;
        chk(bus_out == W'(a + b), "R3 add", bus_out, W'(a + b));
        fn_sel = 2'b01; #1;
        chk(bus_out == d, "R4 sub", bus_out, d);
        fn_sel = 2'b10; #1;
        chk(bus_out == W'(~(a & b)), "R5 nand", bus_out, W'(~(a & b)));
        fn_sel = 2'b11; #1;
        chk(bus_out == W'(a + 1), "R6 inc R1 held A", bus_out, W'(a + 1));
        drv_alu = 1'b0; #1;
        chk(bus_out == '0, "R7 idle zero", bus_out, 0);
        // Branch evaluation with A-B on the bus.
        fn_sel = 2'b01; drv_alu = 1'b1;
        br_opc = 4'b0101; #1;
        chk(cond_now == eq, "R8 eq", cond_now, eq);
        br_opc = 4'b1000; #1;
        chk(cond_now == lt, "R9 lt", cond_now, lt);
        br_opc = 4'b1010; #1;
        chk(cond_now == gt, "R10 gt", cond_now, gt);
        for (int o = 0; o < 16; o += 3) begin
            if (o == 5 || o == 8 || o == 10) continue;
            br_opc = 4'(o); #1;
            chk(cond_now == 1'b0, "R11 other opcode", cond_now, 0);
        end
        // Capture the greater-than result, then hold with a different opcode.
        br_opc = 4'b1010; ld_flag = 1'b1;
        cycle();
        chk(cond_flag == gt, "R12 capture", cond_flag, gt);
        ld_flag = 1'b0; br_opc = 4'b0101;
        cycle();
        chk(cond_flag == gt, "R12 hold", cond_flag, gt);
        drv_alu = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state seen through the outputs.
        drv_alu = 1'b1; fn_sel = 2'b00; #1;
        chk(bus_out == '0, "R13 reset A+B", bus_out, 0);
        fn_sel = 2'b11; #1;
        chk(bus_out == W'(1), "R13 reset A+1", bus_out, 1);
        chk(cond_flag == 1'b0, "R13 reset flag", cond_flag, 0);
        drv_alu = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // Sweep every A against a set of B values.
        for (int a = 0; a < 256; a++)
            for (int bi = 0; bi < 16; bi++)
                test_pair(W'(a), pick_b(bi));
        // R2: B holds while a different value sits on the bus.
        load_pair(8'h10, 8'h03);
        ext_val = 8'h55;
        cycle();
        ext_val = '0;
        fn_sel = 2'b00; drv_alu = 1'b1; #1;
        chk(bus_out == 8'h13, "R2 B held", bus_out, 8'h13);
        // Set the flag, then apply reset mid-run.
        fn_sel = 2'b01; br_opc = 4'b1010; ld_flag = 1'b1;
        cycle();
        ld_flag = 1'b0;
        chk(cond_flag == 1'b1, "R12 set before reset", cond_flag, 1);
        drv_alu = 1'b0; rst_n = 1'b0;
        cycle();
        rst_n = 1'b1;
        chk(cond_flag == 1'b0, "R13 flag cleared", cond_flag, 0);
        fn_sel = 2'b10; drv_alu = 1'b1; #1;
        chk(bus_out == 8'hFF, "R13 operands cleared", bus_out, 8'hFF);
        drv_alu = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule